// File: doc/BRIEF.md
# System Control and Status Port

This block sits on the 8-bit I/O bus of a small home computer and turns byte writes into the individual control lines that the rest of the machine needs. A write to the control address is not stored as a value. It is read as a command code, and each valid code sets or clears exactly one latched output. Those outputs are the bootstrap-mode flag, the floppy controller terminal count, the drive motor enable and the beeper. A read of the same address returns two live status inputs: the floppy controller interrupt and the video frame flyback.

Two neighbouring groups of addresses hold plain stored values. One video address keeps a single brightness bit. A bank of memory-map registers holds one bank number for each 16 KB CPU region. Writing 80h+n to a region's register selects standard block n, so writing 80h, 81h, 82h and 83h to the four registers gives a linear map. Software uses the command port during start-up to leave bootstrap mode, start the motors, pulse the terminal count and sound the beeper.

Top module: `sysctl_port`

## Requirements
- R1: After a synchronous reset, bootstrap mode is active (`boot_mode_o`=1), and `fdc_tc_o`, `motor_o`, `beeper_o`, `video_bright_o` and every bank register are 0.
- R2: Writing code 0 to address F8h clears `boot_mode_o` on the next clock edge. It stays clear until reset, whatever is written afterwards.
- R3: Writing code 5 to F8h sets `fdc_tc_o`, and writing code 6 clears it.
- R4: Writing code 9 to F8h sets `motor_o`, and writing code 10 clears it.
- R5: Writing code 11 to F8h sets `beeper_o`, and writing code 12 clears it.
- R6: Writing any code to F8h other than 0, 5, 6, 9, 10, 11 or 12 leaves every output unchanged. A write to an address outside F0h..F3h, F7h and F8h also changes nothing.
- R7: Repeating a command has no further effect. For example, a second motor-off write leaves the motor off, and a second code 0 leaves bootstrap mode exited.
- R8: While `io_rd` is high and `io_addr` is F8h, `io_rdata` shows the floppy interrupt in bit 5 and frame flyback in bit 6, with all other bits 0. The value is combinational and appears in the same cycle.
- R9: `io_rdata` is 0 when `io_rd` is low or when the address is not F8h.
- R10: A write to F7h latches data bit 7 into `video_bright_o` (80h gives bright, 00h gives dark). The other data bits are ignored.
- R11: A write to F0h+n, for n from 0 to 3, stores the full byte in bank register n, which appears on `bank_map_o[8n+7:8n]`. A write to F8h does not alter any bank register.
- R12: Each command changes only its own output. All other outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data / command code |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data |
| fdc_int_i | input | 1 | Floppy controller interrupt status |
| flyback_i | input | 1 | Video frame flyback status |
| boot_mode_o | output | 1 | Bootstrap mode active |
| fdc_tc_o | output | 1 | Floppy terminal count |
| motor_o | output | 1 | Drive motor enable |
| beeper_o | output | 1 | Beeper on |
| video_bright_o | output | 1 | Bright video select |
| bank_map_o | output | 32 | Four bank registers, region n in bits [8n+7:8n] |

## Verification
The hardest case to reach is the one where ignored codes and repeated commands hit the same outputs that they must leave alone. A check of an idle output would miss a corrupted bit. The stimulus therefore first drives the terminal count, motor and beeper all high. It then writes a spread of unassigned codes and compares the whole output state after each write. Bootstrap exit gets similar treatment: after code 0, the bench writes several other commands and a repeated 0 to show that the flag never returns. Only a mid-run reset brings it back.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int BYTE_W       = 8;
    localparam int STAT_FDC_BIT = 5;
    localparam int STAT_FLY_BIT = 6;
    localparam int BRIGHT_BIT   = 7;

    localparam logic [BYTE_W-1:0] CODE_BOOT_EXIT = 8'd0;
    localparam logic [BYTE_W-1:0] CODE_TC_SET    = 8'd5;
    localparam logic [BYTE_W-1:0] CODE_TC_CLR    = 8'd6;
    localparam logic [BYTE_W-1:0] CODE_MOTOR_SET = 8'd9;
    localparam logic [BYTE_W-1:0] CODE_MOTOR_CLR = 8'd10;
    localparam logic [BYTE_W-1:0] CODE_BEEP_SET  = 8'd11;
    localparam logic [BYTE_W-1:0] CODE_BEEP_CLR  = 8'd12;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BOOT_EXIT,
        OP_TC_SET,
        OP_TC_CLR,
        OP_MOTOR_SET,
        OP_MOTOR_CLR,
        OP_BEEP_SET,
        OP_BEEP_CLR
    } ctl_op_e;

    typedef struct packed {
        logic boot;
        logic tc;
        logic motor;
        logic beep;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{boot: 1'b1, tc: 1'b0, motor: 1'b0, beep: 1'b0};

    function automatic ctl_op_e decode_op(input logic [BYTE_W-1:0] code);
        ctl_op_e op;
        case (code)
            CODE_BOOT_EXIT: op = OP_BOOT_EXIT;
            CODE_TC_SET:    op = OP_TC_SET;
            CODE_TC_CLR:    op = OP_TC_CLR;
            CODE_MOTOR_SET: op = OP_MOTOR_SET;
            CODE_MOTOR_CLR: op = OP_MOTOR_CLR;
            CODE_BEEP_SET:  op = OP_BEEP_SET;
            CODE_BEEP_CLR:  op = OP_BEEP_CLR;
            default:        op = OP_NONE;
        endcase
        return op;
    endfunction

    function automatic ctl_state_t apply_op(input ctl_state_t cur, input ctl_op_e op);
        ctl_state_t nxt;
        nxt = cur;
        case (op)
            OP_BOOT_EXIT: nxt.boot  = 1'b0;
            OP_TC_SET:    nxt.tc    = 1'b1;
            OP_TC_CLR:    nxt.tc    = 1'b0;
            OP_MOTOR_SET: nxt.motor = 1'b1;
            OP_MOTOR_CLR: nxt.motor = 1'b0;
            OP_BEEP_SET:  nxt.beep  = 1'b1;
            OP_BEEP_CLR:  nxt.beep  = 1'b0;
            default:      nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/sysctl_cmd_latch.sv
module sysctl_cmd_latch
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_code,
    output ctl_state_t        ctl_o
);

    ctl_state_t ctl_q;
    ctl_op_e    op;

    always_comb begin
        op = cmd_valid ? decode_op(cmd_code) : OP_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= apply_op(ctl_q, op);
        end
    end

    assign ctl_o = ctl_q;

    // R2
    boot_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.boot |=> !ctl_q.boot);

    // R3
    tc_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 8'd5) |=> (ctl_q.tc && $stable(ctl_q.motor) && $stable(ctl_q.beep)));

    // R4
    motor_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 8'd10) |=> (!ctl_q.motor && $stable(ctl_q.tc) && $stable(ctl_q.beep)));

    // R5
    beep_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 8'd11) |=> (ctl_q.beep && $stable(ctl_q.tc) && $stable(ctl_q.motor)));

    // R6
    unassigned_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !(cmd_code inside {8'd0, 8'd5, 8'd6, 8'd9, 8'd10, 8'd11, 8'd12}))
        |=> $stable(ctl_q));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(ctl_q));

endmodule

// File: rtl/sysctl_status_mux.sv
module sysctl_status_mux
    import sysctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CTRL_ADDR = 8'hF8
) (
    input  logic              rd,
    input  logic [BYTE_W-1:0] addr,
    input  logic              fdc_int,
    input  logic              flyback,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] status_word;
    logic              hit;

    always_comb begin
        status_word               = '0;
        status_word[STAT_FDC_BIT] = fdc_int;
        status_word[STAT_FLY_BIT] = flyback;
        hit                       = rd && (addr == CTRL_ADDR);
        rdata                     = hit ? status_word : '0;
    end

    // R9
    always_comb begin
        if (!rd) begin
            rd_idle_zero_chk: assert (rdata == '0);
        end
    end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int                NUM_BANKS  = 4,
    parameter logic [BYTE_W-1:0] BANK_BASE  = 8'hF0,
    parameter logic [BYTE_W-1:0] VIDEO_ADDR = 8'hF7,
    localparam int               MAP_W      = NUM_BANKS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              bright_o,
    output logic [MAP_W-1:0]  bank_o
);

    logic bright_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bright_q <= 1'b0;
        end else if (wr && addr == VIDEO_ADDR) begin
            bright_q <= wdata[BRIGHT_BIT];
        end
    end

    assign bright_o = bright_q;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        localparam logic [BYTE_W-1:0] MY_ADDR = BYTE_W'(BANK_BASE + i);
        logic [BYTE_W-1:0] bank_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q <= '0;
            end else if (wr && addr == MY_ADDR) begin
                bank_q <= wdata;
            end
        end

        assign bank_o[i*BYTE_W +: BYTE_W] = bank_q;

        // R11
        bank_load_chk: assert property (@(posedge clk) disable iff (rst)
            (wr && addr == MY_ADDR) |=> (bank_o[i*BYTE_W +: BYTE_W] == $past(wdata)));
    end

    // R10
    bright_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == VIDEO_ADDR) |=> (bright_o == $past(wdata[BRIGHT_BIT])));

endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
    import sysctl_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR  = 8'hF8,
    parameter logic [7:0] VIDEO_ADDR = 8'hF7,
    parameter logic [7:0] BANK_BASE  = 8'hF0,
    parameter int         NUM_BANKS  = 4,
    localparam int        MAP_W      = NUM_BANKS * 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       io_addr,
    input  logic [7:0]       io_wdata,
    input  logic             io_wr,
    input  logic             io_rd,
    output logic [7:0]       io_rdata,
    input  logic             fdc_int_i,
    input  logic             flyback_i,
    output logic             boot_mode_o,
    output logic             fdc_tc_o,
    output logic             motor_o,
    output logic             beeper_o,
    output logic             video_bright_o,
    output logic [MAP_W-1:0] bank_map_o
);

    ctl_state_t ctl;
    logic       cmd_valid;

    assign cmd_valid = io_wr && (io_addr == CTRL_ADDR);

    sysctl_cmd_latch u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_code  (io_wdata),
        .ctl_o     (ctl)
    );

    sysctl_status_mux #(.CTRL_ADDR(CTRL_ADDR)) u_stat (
        .rd      (io_rd),
        .addr    (io_addr),
        .fdc_int (fdc_int_i),
        .flyback (flyback_i),
        .rdata   (io_rdata)
    );

    sysctl_store #(
        .NUM_BANKS  (NUM_BANKS),
        .BANK_BASE  (BANK_BASE),
        .VIDEO_ADDR (VIDEO_ADDR)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr       (io_wr),
        .addr     (io_addr),
        .wdata    (io_wdata),
        .bright_o (video_bright_o),
        .bank_o   (bank_map_o)
    );

    assign boot_mode_o = ctl.boot;
    assign fdc_tc_o    = ctl.tc;
    assign motor_o     = ctl.motor;
    assign beeper_o    = ctl.beep;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (boot_mode_o && !fdc_tc_o && !motor_o && !beeper_o && !video_bright_o && bank_map_o == '0));

    // R8
    status_read_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == CTRL_ADDR) |->
        (io_rdata[5] == fdc_int_i && io_rdata[6] == flyback_i && io_rdata[7] == 1'b0 && io_rdata[4:0] == 5'd0));

    // R11
    bank_ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == CTRL_ADDR) |=> $stable(bank_map_o));

endmodule

// File: tb/sysctl_port_bench.sv
module sysctl_port_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  io_addr;
    logic [7:0]  io_wdata;
    logic        io_wr;
    logic        io_rd;
    logic [7:0]  io_rdata;
    logic        fdc_int_i;
    logic        flyback_i;
    logic        boot_mode_o;
    logic        fdc_tc_o;
    logic        motor_o;
    logic        beeper_o;
    logic        video_bright_o;
    logic [31:0] bank_map_o;

    always #2 clk = ~clk;

    sysctl_port u_sysctl_port (
        .clk            (clk),
        .rst            (rst),
        .io_addr        (io_addr),
        .io_wdata       (io_wdata),
        .io_wr          (io_wr),
        .io_rd          (io_rd),
        .io_rdata       (io_rdata),
        .fdc_int_i      (fdc_int_i),
        .flyback_i      (flyback_i),
        .boot_mode_o    (boot_mode_o),
        .fdc_tc_o       (fdc_tc_o),
        .motor_o        (motor_o),
        .beeper_o       (beeper_o),
        .video_bright_o (video_bright_o),
        .bank_map_o     (bank_map_o)
    );

    typedef struct {
        bit          is_read;
        logic [36:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;

    logic        m_boot, m_tc, m_motor, m_beep, m_bright;
    logic [31:0] m_bank;

    function automatic logic [36:0] snap_model();
        return {m_boot, m_tc, m_motor, m_beep, m_bright, m_bank};
    endfunction

    // monitor: compares queued expectations shortly after each falling edge
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [36:0] act;
            it  = q.pop_front();
            act = it.is_read ? {29'd0, io_rdata}
                             : {boot_mode_o, fdc_tc_o, motor_o, beeper_o, video_bright_o, bank_map_o};
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic model_reset();
        m_boot = 1'b1; m_tc = 1'b0; m_motor = 1'b0; m_beep = 1'b0;
        m_bright = 1'b0; m_bank = '0;
    endtask

    task automatic do_reset(input string req);
        item_t it;
        @(negedge clk);
        rst = 1'b1; io_wr = 1'b0; io_rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        it.is_read = 1'b0; it.exp = snap_model(); it.req = req;
        q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
        item_t it;
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        if (a == 8'hF8) begin
            case (d)
                8'd0:  m_boot  = 1'b0;
                8'd5:  m_tc    = 1'b1;
                8'd6:  m_tc    = 1'b0;
                8'd9:  m_motor = 1'b1;
                8'd10: m_motor = 1'b0;
                8'd11: m_beep  = 1'b1;
                8'd12: m_beep  = 1'b0;
                default: ;
            endcase
        end else if (a == 8'hF7) begin
            m_bright = d[7];
        end else if (a >= 8'hF0 && a <= 8'hF3) begin
            m_bank[(a - 8'hF0) * 8 +: 8] = d;
        end
        @(negedge clk);
        io_wr = 1'b0;
        it.is_read = 1'b0; it.exp = snap_model(); it.req = req;
        q.push_back(it);
    endtask

    task automatic rd(input logic [7:0] a, input bit strobe, input bit fi, input bit fl, input string req);
        item_t it;
        @(negedge clk);
        io_addr = a; io_rd = strobe; fdc_int_i = fi; flyback_i = fl;
        it.is_read = 1'b1;
        it.exp = (strobe && a == 8'hF8) ? {29'd0, 1'b0, fl, fi, 5'd0} : 37'd0;
        it.req = req;
        q.push_back(it);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; io_addr = '0; io_wdata = '0; io_wr = 1'b0; io_rd = 1'b0;
        fdc_int_i = 1'b0; flyback_i = 1'b0;
        model_reset();
        do_reset("R1");

        // status reads
        rd(8'hF8, 1, 0, 0, "R8");
        rd(8'hF8, 1, 1, 0, "R8");
        rd(8'hF8, 1, 0, 1, "R8");
        rd(8'hF8, 1, 1, 1, "R8");
        rd(8'hF7, 1, 1, 1, "R9");
        rd(8'hF8, 0, 1, 1, "R9");

        // motor, with repeats
        wr(8'hF8, 8'd9,  "R4");
        wr(8'hF8, 8'd9,  "R7");
        wr(8'hF8, 8'd10, "R4");
        wr(8'hF8, 8'd10, "R7");
        // terminal count and beeper
        wr(8'hF8, 8'd5,  "R3");
        wr(8'hF8, 8'd6,  "R3");
        wr(8'hF8, 8'd11, "R5");
        wr(8'hF8, 8'd12, "R5");

        // all controlled outputs high, then unassigned codes
        wr(8'hF8, 8'd5,  "R12");
        wr(8'hF8, 8'd9,  "R12");
        wr(8'hF8, 8'd11, "R12");
        wr(8'hF8, 8'd1,   "R6");
        wr(8'hF8, 8'd7,   "R6");
        wr(8'hF8, 8'd8,   "R6");
        wr(8'hF8, 8'd13,  "R6");
        wr(8'hF8, 8'hFF,  "R6");
        wr(8'hF8, 8'h80,  "R6");
        wr(8'hF4, 8'd10,  "R6");
        wr(8'hF9, 8'd0,   "R6");

        // bootstrap exit, sticky
        wr(8'hF8, 8'd0,  "R2");
        wr(8'hF8, 8'd0,  "R7");
        wr(8'hF8, 8'd10, "R2");
        wr(8'hF8, 8'd6,  "R12");

        // video brightness
        wr(8'hF7, 8'h80, "R10");
        wr(8'hF7, 8'h7F, "R10");
        wr(8'hF7, 8'hFF, "R10");
        wr(8'hF7, 8'h00, "R10");

        // bank map
        for (int i = 0; i < 4; i++) begin
            wr(8'(8'hF0 + i), 8'(8'h80 + i), "R11");
        end
        wr(8'hF2, 8'h85, "R11");
        wr(8'hF8, 8'd12, "R11");
        rd(8'hF8, 1, 1, 0, "R8");

        // reset again mid-run
        do_reset("R1");
        wr(8'hF8, 8'd11, "R5");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule